// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block derives a slower clock from its input clock. Software sets the division ratio by writing a divisor code into a small register file, and it turns the derived clock on or off through an enable bit kept in a separate register. The output is a registered level that changes only on rising edges of the input clock. For a ratio N, each output period is N input cycles long. The output is high for the first ceil(N/2) cycles of the period and low for the remaining floor(N/2) cycles.

A divisor change never cuts a period short. An accepted code is held pending, and it replaces the running ratio only at the end of the current output period. During that interval the status register reports busy. Gating is handled the same way: the enable bit is sampled only at a period boundary, so the output never shows a shortened high pulse. The divisor field is `DIV_W` bits wide, 5 by default. When `DIV_W` is 6 the block is in extended mode, and its top field bit brings in a fixed multiply-by-64 prescale.

Top module: `clkdiv_gated`

## Requirements
- R1: After reset, clk_out is low, the status, divisor and enable registers all read 0, and the running ratio is mask+1.
- R2: A divisor code of zero selects a ratio of mask+1: 32 when DIV_W=5, and 64 when DIV_W=6.
- R3: A nonzero code n below 32 selects a ratio of n. Each period is high for ceil(n/2) input cycles and then low for floor(n/2). A ratio of 1 gives a constant high output while enabled.
- R4: With DIV_W=6, a code with bit 5 set selects 64 times the value of bits 4:0. If bits 4:0 are zero, the ratio is 64. With DIV_W=5, only bits 4:0 of the written data are kept.
- R5: Address 0 is status. Bits 3 and 4 both read 1 from the cycle after an accepted write to the divisor register (address 1) until the switchover, and every other status bit reads 0.
- R6: A pending ratio is loaded only at the end of the current output period, which completes with the old ratio. Busy clears on the same edge.
- R7: A divisor write made while busy reads 1 is ignored. This includes the cycle in which busy clears. The divisor readback and the ratio that follows are unchanged by it.
- R8: Address 2 holds an 8-bit enable register. All 8 bits are stored and read back as written, and bit 0 gates the output. Writes to address 3 change nothing, and address 3 reads 0.
- R9: The enable bit is sampled only at period boundaries. When it is cleared, the current period finishes before the output stays low. When it is set, the output starts at the beginning of a period.
- R10: A divisor write accepted in the very cycle that ends a period does not apply at that boundary. It waits one full period of the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status, 1 divisor, 2 enable, 3 unused) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| clk_out | output | 1 | Divided and gated clock level |

## Verification
Two events can coincide: a register write and the end of an output period. The critical case is a divisor write that lands on the final cycle of a period. If busy is low in that cycle, the write must be accepted but deferred for a whole further period. If busy is high, the write is lost even though busy drops on that same edge. The bench provokes both cases by using its own period model to hold off until the boundary cycle and then writing. It judges the result from clk_out and the status and divisor readbacks on every cycle, on a default instance and an extended instance driven in parallel.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int RATIO_W   = 12;
    localparam int CODE_MAXW = 6;
    localparam int BUSY_BIT_A = 3;
    localparam int BUSY_BIT_B = 4;

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef enum logic [1:0] {
        RA_STATUS  = 2'd0,
        RA_DIVISOR = 2'd1,
        RA_ENABLE  = 2'd2,
        RA_SPARE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        ratio_t cnt;
        ratio_t cur;
        logic   gate;
        logic   out;
    } period_state_t;

    // Effective ratio for a divisor code; a zero result wraps to mask+1.
    function automatic ratio_t code_to_ratio(logic [CODE_MAXW-1:0] code,
                                             logic ext, int unsigned div_w);
        ratio_t r;
        if (ext && code[5])
            r = ratio_t'(code[4:0]) << 6;
        else
            r = ratio_t'(code);
        if (r == '0)
            r = ratio_t'(1) << div_w;
        return r;
    endfunction

    function automatic ratio_t high_len(ratio_t r);
        return (r + ratio_t'(1)) >> 1;
    endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int DIV_W  = 5,
    parameter int DATA_W = 8,
    parameter int EN_BIT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              swap,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    output ratio_t            pend_ratio,
    output logic              en_bit,
    output logic [DIV_W-1:0]  field
);
    localparam logic EXT_MODE = (DIV_W == 6);

    reg_addr_e         sel;
    logic [DATA_W-1:0] en_reg;
    logic [CODE_MAXW-1:0] code_x;
    logic              div_accept;

    always_comb begin
        sel        = reg_addr_e'(addr);
        code_x     = '0;
        code_x[DIV_W-1:0] = wdata[DIV_W-1:0];
        div_accept = wr && (sel == RA_DIVISOR) && !busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            field      <= '0;
            en_reg     <= '0;
            busy       <= 1'b0;
            pend_ratio <= code_to_ratio('0, EXT_MODE, DIV_W);
        end else begin
            if (swap)
                busy <= 1'b0;
            if (div_accept) begin
                field      <= wdata[DIV_W-1:0];
                pend_ratio <= code_to_ratio(code_x, EXT_MODE, DIV_W);
                busy       <= 1'b1;
            end
            if (wr && (sel == RA_ENABLE))
                en_reg <= wdata;
        end
    end

    assign en_bit = en_reg[EN_BIT];

    always_comb begin
        rdata = '0;
        unique case (sel)
            RA_STATUS: begin
                rdata[BUSY_BIT_A] = busy;
                rdata[BUSY_BIT_B] = busy;
            end
            RA_DIVISOR: rdata[DIV_W-1:0] = field;
            RA_ENABLE:  rdata = en_reg;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/clkdiv_period.sv
module clkdiv_period
    import clkdiv_pkg::*;
#(
    parameter ratio_t INIT_RATIO = 12'd32
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   busy,
    input  ratio_t pend_ratio,
    input  logic   en_bit,
    output logic   swap,
    output logic   at_end,
    output ratio_t cur_ratio,
    output ratio_t cnt,
    output logic   gate_on,
    output logic   clk_out
);
    period_state_t st, st_nx;

    always_comb begin
        at_end      = (st.cnt == st.cur - ratio_t'(1));
        swap        = at_end && busy;
        st_nx.cnt   = at_end ? '0 : st.cnt + ratio_t'(1);
        st_nx.cur   = swap ? pend_ratio : st.cur;
        st_nx.gate  = at_end ? en_bit : st.gate;
        st_nx.out   = st_nx.gate && (st_nx.cnt < high_len(st_nx.cur));
    end

    always_ff @(posedge clk) begin
        if (rst)
            st <= '{cnt: '0, cur: INIT_RATIO, gate: 1'b0, out: 1'b0};
        else
            st <= st_nx;
    end

    assign cur_ratio = st.cur;
    assign cnt       = st.cnt;
    assign gate_on   = st.gate;
    assign clk_out   = st.out;
endmodule

// File: rtl/clkdiv_gated.sv
module clkdiv_gated
    import clkdiv_pkg::*;
#(
    parameter int DIV_W  = 5,
    parameter int EN_BIT = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       clk_out
);
    localparam int     DATA_W     = 8;
    localparam ratio_t INIT_RATIO = ratio_t'(1) << DIV_W;

    logic             busy_w;
    logic             swap_w;
    logic             en_w;
    logic             at_end_w;
    logic             gate_w;
    ratio_t           pend_w;
    ratio_t           cur_w;
    ratio_t           cnt_w;
    logic [DIV_W-1:0] field_w;

    clkdiv_regs #(.DIV_W(DIV_W), .DATA_W(DATA_W), .EN_BIT(EN_BIT)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .swap       (swap_w),
        .rdata      (reg_rdata),
        .busy       (busy_w),
        .pend_ratio (pend_w),
        .en_bit     (en_w),
        .field      (field_w)
    );

    clkdiv_period #(.INIT_RATIO(INIT_RATIO)) u_period (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy_w),
        .pend_ratio (pend_w),
        .en_bit     (en_w),
        .swap       (swap_w),
        .at_end     (at_end_w),
        .cur_ratio  (cur_w),
        .cnt        (cnt_w),
        .gate_on    (gate_w),
        .clk_out    (clk_out)
    );
endmodule

// File: rtl/clkdiv_gated_chk.sv
module clkdiv_gated_chk
    import clkdiv_pkg::*;
#(
    parameter int DIV_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic             busy,
    input logic [DIV_W-1:0] field,
    input logic             at_end,
    input ratio_t           cur_ratio,
    input ratio_t           cnt,
    input logic             gate_on,
    input logic             clk_out
);
    // R5: an accepted divisor write raises busy on the next cycle
    assert_busy_set_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd1 && !busy) |=> busy);

    // R6: ratio changes only right after a period end
    assert_switch_at_end_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_ratio) |-> $past(at_end));

    // R6: busy drops only at a period end
    assert_busy_clear_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(at_end));

    // R7: a divisor write while busy leaves the field alone
    assert_field_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_wr && reg_addr == 2'd1) |=> $stable(field));

    // R9: gate state moves only at a period end
    assert_gate_at_end_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(gate_on) |-> $past(at_end));

    // R9: gated-off output is low
    assert_gated_low_R9: assert property (@(posedge clk) disable iff (rst)
        !gate_on |-> !clk_out);

    // R3: period counter stays inside the running ratio
    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
        cnt < cur_ratio);
endmodule

bind clkdiv_gated clkdiv_gated_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .busy      (busy_w),
    .field     (field_w),
    .at_end    (at_end_w),
    .cur_ratio (cur_w),
    .cnt       (cnt_w),
    .gate_on   (gate_w),
    .clk_out   (clk_out)
);

// File: tb/clkdiv_gated_tb.sv
`timescale 1ns/1ps
module clkdiv_gated_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] rd [2];
    logic       co [2];

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    clkdiv_gated #(.DIV_W(5)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd[0]), .clk_out(co[0]));

    clkdiv_gated #(.DIV_W(6)) u_dut_ext (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd[1]), .clk_out(co[1]));

    // behavioural reference state per instance
    int m_cnt[2], m_cur[2], m_pend[2], m_busy[2], m_gate[2], m_out[2];
    int m_field[2], m_en[2];
    int mask[2] = '{31, 63};
    int ext[2]  = '{0, 1};

    function automatic int ratio_of(int code, int k);
        int r;
        if (ext[k] != 0 && (code & 32) != 0) r = 64 * (code & 31);
        else r = code;
        if (r == 0) r = mask[k] + 1;
        return r;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_cnt[k] = 0; m_cur[k] = mask[k] + 1; m_pend[k] = mask[k] + 1;
            m_busy[k] = 0; m_gate[k] = 0; m_out[k] = 0;
            m_field[k] = 0; m_en[k] = 0;
        end
    endtask

    task automatic model_step(bit wr, int addr, int data);
        for (int k = 0; k < 2; k++) begin
            bit end_c = (m_cnt[k] == m_cur[k] - 1);
            bit sw = end_c && (m_busy[k] != 0);
            int ncnt = end_c ? 0 : m_cnt[k] + 1;
            int ncur = sw ? m_pend[k] : m_cur[k];
            int ngate = end_c ? (m_en[k] & 1) : m_gate[k];
            int nbusy = sw ? 0 : m_busy[k];
            if (wr && addr == 1 && m_busy[k] == 0) begin
                m_field[k] = data & mask[k];
                m_pend[k] = ratio_of(data & mask[k], k);
                nbusy = 1;
            end
            if (wr && addr == 2) m_en[k] = data & 255;
            m_cnt[k] = ncnt; m_cur[k] = ncur; m_gate[k] = ngate; m_busy[k] = nbusy;
            m_out[k] = (ngate != 0 && ncnt < (ncur + 1) / 2) ? 1 : 0;
        end
    endtask

    function automatic int exp_rd(int k, int addr);
        case (addr)
            0: return (m_busy[k] != 0) ? 8'h18 : 0;
            1: return m_field[k];
            2: return m_en[k];
            default: return 0;
        endcase
    endfunction

    task automatic compare(string req);
        for (int k = 0; k < 2; k++) begin
            n_vec++;
            if (int'(co[k]) != m_out[k]) begin
                n_bad++;
                $display("FAIL %s inst%0d clk_out actual=%0d expected=%0d t=%0t",
                         req, k, co[k], m_out[k], $time);
            end
            n_vec++;
            if (int'(rd[k]) != exp_rd(k, int'(reg_addr))) begin
                n_bad++;
                $display("FAIL %s inst%0d rdata@%0d actual=%0h expected=%0h t=%0t",
                         req, k, reg_addr, rd[k], exp_rd(k, int'(reg_addr)), $time);
            end
        end
    endtask

    // one input cycle: drive, let the edge pass, update model, compare
    task automatic tick(bit wr, int addr, int data, string req);
        reg_wr = wr; reg_addr = 2'(addr); reg_wdata = 8'(data);
        @(posedge clk);
        model_step(wr, addr, data);
        @(negedge clk);
        compare(req);
    endtask

    task automatic idle(int n, int addr, string req);
        for (int i = 0; i < n; i++) tick(0, addr, 0, req);
    endtask

    task automatic wait_end0(string req);
        while (m_cnt[0] != m_cur[0] - 1) tick(0, 0, 0, req);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state of every register and the output
        tick(0, 0, 0, "R1");
        tick(0, 1, 0, "R1");
        tick(0, 2, 0, "R1");
        tick(0, 3, 0, "R1");
        // R8/R9: enable, output starts at a period start; R2 ratio 32/64
        tick(1, 2, 8'h01, "R8");
        idle(140, 0, "R2");
        // R5/R6: new ratio 5, then a write while busy (R7) is dropped
        tick(1, 1, 5, "R5");
        tick(1, 1, 3, "R7");
        idle(70, 0, "R6");
        tick(0, 1, 0, "R7");
        // R3: ratio 1 and odd/even ratios
        tick(1, 1, 1, "R3");
        idle(80, 0, "R3");
        tick(1, 1, 6, "R3");
        idle(30, 0, "R3");
        // R10: write landing on the period-end cycle with busy low
        wait_end0("R10");
        tick(1, 1, 4, "R10");
        idle(20, 0, "R10");
        // R7: write on the cycle busy clears is ignored
        tick(1, 1, 7, "R7");
        wait_end0("R7");
        tick(1, 1, 9, "R7");
        idle(25, 1, "R7");
        // R4: prescale codes
        tick(1, 1, 8'h21, "R4");
        idle(200, 0, "R4");
        tick(1, 1, 8'h20, "R4");
        idle(200, 0, "R4");
        tick(1, 1, 8'h23, "R4");
        idle(420, 0, "R4");
        tick(0, 1, 0, "R4");
        // R9/R8: disable mid-period with other bits, readback, re-enable
        tick(1, 1, 10, "R9");
        idle(30, 0, "R9");
        idle(3, 0, "R9");
        tick(1, 2, 8'hA4, "R9");
        tick(0, 2, 0, "R8");
        idle(30, 0, "R9");
        tick(1, 2, 8'hA5, "R9");
        idle(30, 2, "R8");
        // R8: address 3 writes have no effect
        tick(1, 3, 8'hFF, "R8");
        tick(0, 3, 0, "R8");
        tick(0, 2, 0, "R8");
        tick(0, 1, 0, "R8");
        idle(30, 0, "R8");
        // R2: back to code zero
        tick(1, 1, 0, "R2");
        idle(140, 0, "R2");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule